// File: doc/BRIEF.md
# Fault-tolerant one-hot switch driver

This block turns a small command code from a supervising microcontroller into the enable lines of a cell-balancing switch matrix. The code selects which single cell is tied to the shared balancing bus. Each enable line drives one double-pole switch. Two enables active at the same time would short two cells through the bus. The command is captured in a register on every clock edge, and the switch enables follow the registered value.

The decoded vector can pass through a safety filter before it reaches the pins. The filter lets through a vector with zero or one active bit and forces every enable low for any other vector. A build-time parameter picks the hardening scheme, and the four schemes trade area for protection against upsets in different ways. The bare scheme uses one register, one decoder and no filter. The single-filter scheme adds one filter. The triplicated-filter scheme feeds one decoder into three filter copies and combines them with a bitwise AND. The majority scheme triplicates the register and the decoder and takes a 2-of-3 vote per bit, with no filter.

Test-only XOR masks corrupt each decoded copy, so a bench can model an upset in any one copy. In normal use these masks are tied to zero. A diagnostic flag reports every cycle in which a filter copy rejected a vector.

Top module: `bal_switch_driver`

## Requirements
- R1: A synchronous active-high `rst`, sampled on a rising clock edge, clears the command register or registers, so that after that edge `swEn` is all zero and `blockFlag` is low (with zero fault masks).
- R2: With zero fault masks, command codes 1 to 11 produce `swEn` with only bit (code-1) set, which enables switch number `code`. This holds in all four schemes.
- R3: Command codes 0, 12, 13, 14 and 15 produce an all-zero `swEn`.
- R4: `cmdCode` is captured on the rising clock edge. A change of `cmdCode` between edges does not reach `swEn` until the next rising edge.
- R5: In the single-filter scheme (`MODE` = HARD_SINGLE_FILTER, which uses mask copy 0 only), a corrupted vector with one bit set passes unchanged. A corrupted vector with two or more bits set gives an all-zero `swEn` and raises `blockFlag` in the same cycle.
- R6: In the triplicated-filter scheme (`MODE` = HARD_TRI_FILTER), bit i of `swEn` is set only when all three filtered copies have bit i set. `blockFlag` is high when any copy was rejected.
- R7: In the majority scheme (`MODE` = HARD_TMR), a corruption confined to any one mask copy leaves `swEn` equal to the clean decode. `blockFlag` stays low.
- R8: In the bare scheme (`MODE` = HARD_PLAIN, which uses mask copy 0 only), the masked vector reaches `swEn` unchanged, even when several bits are set. `blockFlag` stays low.
- R9: In both filtered schemes, `swEn` never has more than one bit set, for any fault mask.
- R10: `faultMask` holds the three per-copy masks: copy k occupies bits [k*11 +: 11], and bit i of a copy toggles decoded bit i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdCode | input | 4 | Switch-selection code from the microcontroller |
| faultMask | input | 33 | Test-only XOR masks, 11 bits per copy, copy k at [k*11 +: 11] |
| swEn | output | 11 | Switch enables; bit i closes switch i+1 |
| blockFlag | output | 1 | High while any filter copy rejects a multi-hot vector |

## Verification
All eleven valid codes and all five unused codes are applied to four instances, one built in each scheme, to show that every scheme decodes the same way when no fault is injected. Single-copy masks then add a bit, remove the selected bit, or move it to another position. These three cases separate the schemes: the bare scheme lets a double enable through, the single filter blocks a double but passes a moved bit, the AND of three filters turns any disagreement into all-off, and the vote hides any one copy. A code changed between two clock edges shows that the enables come from the register. A reset applied while a switch is active shows that the enables are cleared.

// File: rtl/swd_pkg.sv
package swd_pkg;

  typedef enum logic [1:0] {
    HARD_PLAIN         = 2'd0,
    HARD_SINGLE_FILTER = 2'd1,
    HARD_TRI_FILTER    = 2'd2,
    HARD_TMR           = 2'd3
  } hard_mode_e;

  localparam int NCOPY = 3;

  // Routing strobes from the control side to the datapath.
  typedef struct packed {
    logic tripleCmd;     // three independent command copies, majority vote
    logic useFilter;     // the safety filter is on the output path
    logic andVote;       // three filter copies combined by bitwise AND
  } route_t;

endpackage

// File: rtl/swd_filter.sv
module swd_filter #(
  parameter int NUM_SW = 11
) (
  input  logic [NUM_SW-1:0] vecIn,
  output logic [NUM_SW-1:0] vecOut,
  output logic              blocked
);

  logic multiHot;

  // Clearing the lowest set bit leaves something only if two or more were set.
  assign multiHot = |(vecIn & (vecIn - NUM_SW'(1)));
  assign blocked  = multiHot;
  assign vecOut   = multiHot ? '0 : vecIn;

  // R9: a filter copy never drives more than one enable
  always_comb begin
    p_filter_onehot_r9: assert ($onehot0(vecOut));
  end

endmodule

// File: rtl/swd_ctrl.sv
module swd_ctrl
  import swd_pkg::*;
#(
  parameter int         CODE_W = 4,
  parameter hard_mode_e MODE   = HARD_TRI_FILTER
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] cmdCode,
  output logic [CODE_W-1:0] codeQ [NCOPY],
  output route_t            route
);

  assign route.tripleCmd = (MODE == HARD_TMR);
  assign route.useFilter = (MODE == HARD_SINGLE_FILTER) || (MODE == HARD_TRI_FILTER);
  assign route.andVote   = (MODE == HARD_TRI_FILTER);

  generate
    if (MODE == HARD_TMR) begin : g_triple
      for (genvar k = 0; k < NCOPY; k++) begin : g_copy
        always_ff @(posedge clk) begin
          if (rst) codeQ[k] <= '0;
          else     codeQ[k] <= cmdCode;
        end
      end
    end else begin : g_single
      logic [CODE_W-1:0] codeReg;
      always_ff @(posedge clk) begin
        if (rst) codeReg <= '0;
        else     codeReg <= cmdCode;
      end
      for (genvar k = 0; k < NCOPY; k++) begin : g_alias
        assign codeQ[k] = codeReg;
      end
    end
  endgenerate

  // R4: each copy holds the code sampled at the previous edge
  p_capture_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> codeQ[0] == $past(cmdCode));

  // R7: the command copies never diverge (upsets are modelled after decode)
  p_copies_agree_r7: assert property (@(posedge clk) disable iff (rst)
    (codeQ[1] == codeQ[0]) && (codeQ[2] == codeQ[0]));

endmodule

// File: rtl/swd_datapath.sv
module swd_datapath
  import swd_pkg::*;
#(
  parameter int NUM_SW = 11,
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0]       codeQ [NCOPY],
  input  logic [NCOPY*NUM_SW-1:0] faultMask,
  input  route_t                  route,
  output logic [NUM_SW-1:0]       swEn,
  output logic                    blockFlag
);

  logic [NUM_SW-1:0] decVec   [NCOPY];
  logic [NUM_SW-1:0] faultVec [NCOPY];
  logic [NUM_SW-1:0] cleanVec [NCOPY];
  logic [NCOPY-1:0]  blockVec;

  function automatic logic [NUM_SW-1:0] decodeCode(input logic [CODE_W-1:0] c);
    logic [NUM_SW-1:0] v;
    v = '0;
    for (int i = 0; i < NUM_SW; i++) begin
      if (c == CODE_W'(i + 1)) v[i] = 1'b1;
    end
    return v;
  endfunction

  generate
    for (genvar k = 0; k < NCOPY; k++) begin : g_copy
      assign decVec[k]   = decodeCode(codeQ[k]);
      assign faultVec[k] = decVec[k] ^ faultMask[k*NUM_SW +: NUM_SW];
      swd_filter #(.NUM_SW(NUM_SW)) u_filter (
        .vecIn  (faultVec[k]),
        .vecOut (cleanVec[k]),
        .blocked(blockVec[k])
      );
    end
  endgenerate

  always_comb begin
    if (route.tripleCmd) begin
      swEn      = (faultVec[0] & faultVec[1]) | (faultVec[0] & faultVec[2])
                | (faultVec[1] & faultVec[2]);
      blockFlag = 1'b0;
    end else if (!route.useFilter) begin
      swEn      = faultVec[0];
      blockFlag = 1'b0;
    end else if (route.andVote) begin
      swEn      = cleanVec[0] & cleanVec[1] & cleanVec[2];
      blockFlag = |blockVec;
    end else begin
      swEn      = cleanVec[0];
      blockFlag = blockVec[0];
    end
  end

endmodule

// File: rtl/bal_switch_driver.sv
module bal_switch_driver
  import swd_pkg::*;
#(
  parameter int         NUM_SW = 11,
  parameter int         CODE_W = 4,
  parameter hard_mode_e MODE   = HARD_TRI_FILTER
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CODE_W-1:0]       cmdCode,
  input  logic [NCOPY*NUM_SW-1:0] faultMask,
  output logic [NUM_SW-1:0]       swEn,
  output logic                    blockFlag
);

  localparam bit FILTERED = (MODE == HARD_SINGLE_FILTER) || (MODE == HARD_TRI_FILTER);

  logic [CODE_W-1:0] codeQ [NCOPY];
  route_t            route;

  swd_ctrl #(.CODE_W(CODE_W), .MODE(MODE)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .cmdCode(cmdCode),
    .codeQ  (codeQ),
    .route  (route)
  );

  swd_datapath #(.NUM_SW(NUM_SW), .CODE_W(CODE_W)) u_dp (
    .codeQ    (codeQ),
    .faultMask(faultMask),
    .route    (route),
    .swEn     (swEn),
    .blockFlag(blockFlag)
  );

  // R9: filtered schemes never enable two switches
  p_at_most_one_r9: assert property (@(posedge clk) disable iff (rst)
    FILTERED |-> $onehot0(swEn));

  // R8 / R7: the unfiltered schemes never report a rejection
  p_noflag_unfiltered_r8: assert property (@(posedge clk) disable iff (rst)
    !FILTERED |-> !blockFlag);

  // R5: with no injected fault, nothing is ever rejected
  p_noflag_clean_r5: assert property (@(posedge clk) disable iff (rst)
    (faultMask == '0) |-> !blockFlag);

  // R1: a reset edge leaves every switch open
  p_reset_clears_r1: assert property (@(posedge clk)
    ($past(rst) && (faultMask == '0)) |-> (swEn == '0));

endmodule

// File: tb/bal_switch_driver_tb.sv
module bal_switch_driver_tb;
  import swd_pkg::*;

  localparam int NSW = 11;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [3:0]     cmdCode = '0;
  logic [3*NSW-1:0] faultMask = '0;

  logic [NSW-1:0] swTri, swSgl, swTmr, swPln;
  logic           flTri, flSgl, flTmr, flPln;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;   // 50 MHz

  bal_switch_driver #(.MODE(HARD_TRI_FILTER)) u_dut (
    .clk(clk), .rst(rst), .cmdCode(cmdCode), .faultMask(faultMask),
    .swEn(swTri), .blockFlag(flTri));
  bal_switch_driver #(.MODE(HARD_SINGLE_FILTER)) u_single (
    .clk(clk), .rst(rst), .cmdCode(cmdCode), .faultMask(faultMask),
    .swEn(swSgl), .blockFlag(flSgl));
  bal_switch_driver #(.MODE(HARD_TMR)) u_tmr (
    .clk(clk), .rst(rst), .cmdCode(cmdCode), .faultMask(faultMask),
    .swEn(swTmr), .blockFlag(flTmr));
  bal_switch_driver #(.MODE(HARD_PLAIN)) u_plain (
    .clk(clk), .rst(rst), .cmdCode(cmdCode), .faultMask(faultMask),
    .swEn(swPln), .blockFlag(flPln));

  task automatic chk(input string tag, input logic [NSW-1:0] got, input logic [NSW-1:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  function automatic logic [NSW-1:0] oneHot(input int code);
    logic [NSW-1:0] v;
    v = '0;
    if (code >= 1 && code <= NSW) v[code-1] = 1'b1;
    return v;
  endfunction

  function automatic logic [3*NSW-1:0] maskOf(input int copy, input logic [NSW-1:0] m);
    logic [3*NSW-1:0] v;
    v = '0;
    v[copy*NSW +: NSW] = m;
    return v;
  endfunction

  // Drive on the falling edge, let one rising edge load, sample after it.
  task automatic step(input logic [3:0] code, input logic [3*NSW-1:0] mask);
    @(negedge clk);
    cmdCode   = code;
    faultMask = mask;
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 tri reset", swTri, '0);
    chk("R1 tmr reset", swTmr, '0);
    chk("R1 flag reset", {10'b0, flTri | flSgl}, '0);
    @(negedge clk);
    rst = 1'b0;
    step(4'd5, '0);
    chk("R1 load before reset", swTri, oneHot(5));
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    chk("R1 tri reset while active", swTri, '0);
    chk("R1 plain reset while active", swPln, '0);
    chk("R1 tmr reset while active", swTmr, '0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_decode();
    for (int c = 1; c <= NSW; c++) begin
      step(4'(c), '0);
      chk($sformatf("R2 tri code %0d", c), swTri, oneHot(c));
      chk($sformatf("R2 single code %0d", c), swSgl, oneHot(c));
      chk($sformatf("R2 tmr code %0d", c), swTmr, oneHot(c));
      chk($sformatf("R2 plain code %0d", c), swPln, oneHot(c));
    end
  endtask

  task automatic t_unused();
    for (int c = 0; c < 16; c++) begin
      if (c == 0 || c > NSW) begin
        step(4'(c), '0);
        chk($sformatf("R3 tri code %0d", c), swTri, '0);
        chk($sformatf("R3 tmr code %0d", c), swTmr, '0);
        chk($sformatf("R3 plain code %0d", c), swPln, '0);
      end
    end
  endtask

  task automatic t_registered();
    step(4'd5, '0);
    @(negedge clk);
    cmdCode = 4'd7;
    #3;
    chk("R4 mid-cycle change hidden (tri)", swTri, oneHot(5));
    chk("R4 mid-cycle change hidden (plain)", swPln, oneHot(5));
    @(posedge clk);
    #2;
    chk("R4 change after edge", swTri, oneHot(7));
  endtask

  task automatic t_single_filter();
    // code 3 -> bit 2; mask adds bit 6 in copy 0
    step(4'd3, maskOf(0, 11'b000_0100_0000));
    chk("R5 single blocks double", swSgl, '0);
    chk("R5 single flag on double", {10'b0, flSgl}, 11'd1);
    // mask moves bit 2 to bit 6
    step(4'd3, maskOf(0, 11'b000_0100_0100));
    chk("R5 single passes moved bit", swSgl, oneHot(7));
    chk("R5 single no flag on moved bit", {10'b0, flSgl}, '0);
  endtask

  task automatic t_tri_filter();
    step(4'd3, maskOf(1, 11'b000_0100_0000));
    chk("R6 tri copy1 double -> off", swTri, '0);
    chk("R6 tri flag on copy1 double", {10'b0, flTri}, 11'd1);
    step(4'd3, maskOf(2, 11'b000_0000_0100));
    chk("R6 tri copy2 drops bit -> off", swTri, '0);
    chk("R6 tri no flag on dropped bit", {10'b0, flTri}, '0);
    step(4'd3, maskOf(0, 11'b000_0100_0100));
    chk("R6 tri copy0 moved bit -> off", swTri, '0);
    step(4'd3, '0);
    chk("R6 tri clean after faults", swTri, oneHot(3));
  endtask

  task automatic t_tmr();
    step(4'd3, maskOf(1, '1));
    chk("R7 tmr masks copy1 all ones", swTmr, oneHot(3));
    chk("R7 tmr no flag", {10'b0, flTmr}, '0);
    step(4'd3, maskOf(0, 11'b000_0000_0100));
    chk("R7 tmr masks copy0 dropped bit", swTmr, oneHot(3));
    step(4'd9, maskOf(2, 11'b100_0000_0001));
    chk("R10 tmr masks copy2 at its field", swTmr, oneHot(9));
  endtask

  task automatic t_plain();
    step(4'd3, maskOf(0, 11'b000_0100_0000));
    chk("R8 plain passes double", swPln, 11'b000_0100_0100);
    chk("R8 plain no flag", {10'b0, flPln}, '0);
    step(4'd3, maskOf(1, 11'b000_0100_0000));
    chk("R10 plain ignores copy1 field", swPln, oneHot(3));
  endtask

  task automatic t_at_most_one();
    logic [NSW-1:0] pats [4];
    pats[0] = 11'b111_1111_1111;
    pats[1] = 11'b000_0000_0011;
    pats[2] = 11'b100_0000_0000;
    pats[3] = 11'b010_1010_1010;
    for (int cp = 0; cp < 3; cp++) begin
      for (int p = 0; p < 4; p++) begin
        step(4'd1, maskOf(cp, pats[p]));
        chk($sformatf("R9 tri ones<=1 copy%0d pat%0d", cp, p),
            11'($countones(swTri) > 1), '0);
        chk($sformatf("R9 single ones<=1 copy%0d pat%0d", cp, p),
            11'($countones(swSgl) > 1), '0);
      end
    end
    step(4'd1, '0);
  endtask

  initial begin : watchdog
    #(20 * 100_000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin : main
    t_reset();
    t_decode();
    t_unused();
    t_registered();
    t_single_filter();
    t_tri_filter();
    t_tmr();
    t_plain();
    t_at_most_one();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule